// File: doc/BRIEF.md
# Flash Program/Erase Status Poller

This block keeps the status byte that a host reads back while a flash program or erase operation is in flight, and it stands in for the time those operations take with a cycle counter. A command sequencer (not part of this block) hands it one-cycle start pulses: a program start together with the data byte being written, a chip-erase start or a sector-erase start. The host's status reads arrive as a one-cycle strobe. The block returns the byte, a busy level and a one-cycle completion pulse. The sequencer uses that pulse to leave its program or erase state.

The byte follows the usual polling convention. Bit 6 alternates on every read, so a host can watch it flip while the device is working. Bit 7 carries the complement of the programmed data's top bit once a program has been taken, and it inverts when an erase finishes. A program is treated as immediate. A chip erase and a sector erase each last their own parameterised number of clock cycles. Reset is synchronous and active low.

Top module: `flash_poll_status`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block returns to its idle state: `status_q` = 0x00, `busy` = 0, `op_done` = 0, `cmd_active` = 0, and the timer is stopped. This also applies when an erase is in progress, and no completion pulse follows the reset.
- R2: A `status_rd` strobe sampled at an edge inverts status bit 6 at that edge. The value seen during the strobe cycle is the value before the inversion, so back-to-back reads starting from 0x00 return 0x00, 0x40, 0x00, 0x40.
- R3: An accepted program start sets status bit 7 to the inverse of `prog_data[7]` at the sampling edge. Bits 5..0 are left unchanged. A read in the same cycle still toggles bit 6.
- R4: One cycle after an accepted program start, `op_done` is high for exactly one cycle. `busy` stays low throughout.
- R5: An accepted chip- or sector-erase start clears `status_q` to 0x00 at the sampling edge and raises `busy` at that same edge. A read strobe in the start cycle returns the old value, and its bit-6 toggle is discarded.
- R6: `busy` stays high for exactly `SECTOR_CYCLES` cycles after a sector erase and for exactly `CHIP_CYCLES` cycles after a chip erase.
- R7: At the edge where the erase time runs out, `busy` falls, status bit 7 inverts and `op_done` rises for one cycle.
- R8: Any start pulse is ignored while `busy` is high or while a program completion is pending. `busy` timing and `status_q` then behave as if the pulse were absent.
- R9: A read strobe in the cycle where an erase expires applies both effects at that edge: bit 6 toggles and bit 7 inverts.
- R10: When several starts arrive together in an idle cycle, chip erase wins over sector erase, and sector erase wins over program.
- R11: `cmd_active` is high whenever a program or erase command is current: from the accepting edge until the edge that raises `op_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_start | input | 1 | One-cycle program start pulse |
| prog_data | input | 8 | Data byte being programmed |
| chip_erase_start | input | 1 | One-cycle chip-erase start pulse |
| sector_erase_start | input | 1 | One-cycle sector-erase start pulse |
| status_rd | input | 1 | One-cycle status read strobe |
| status_q | output | 8 | Status byte presented to the host |
| busy | output | 1 | Erase timer running |
| op_done | output | 1 | One-cycle completion pulse to the sequencer |
| cmd_active | output | 1 | A program or erase command is current |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a host poll and the end of an erase: the toggle of bit 6 and the inversion of bit 7 both hit the byte at that edge. The bench polls on every cycle of a short sector erase, so one read is guaranteed to coincide with the expiry. The read after it must then show both bits changed.

The second pair is a poll and an erase start. The clear must win, so the next read has to return 0x00 and not 0x40.

// File: rtl/flash_poll_pkg.sv
// Shared constants and types for the status poller.
// Assumes an 8-bit status byte with the toggle and polling bits at
// the positions a host driver expects.
package flash_poll_pkg;
    localparam int STAT_W   = 8;
    localparam int TGL_BIT  = 6;
    localparam int POLL_BIT = 7;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_PROG   = 2'd1,
        OP_SECTOR = 2'd2,
        OP_CHIP   = 2'd3
    } op_kind_e;
endpackage

// File: rtl/poll_op_timer.sv
// Erase duration timer.
// Loads a per-operation cycle count on an accepted start and counts
// down to zero. It flags expiry for one cycle and then stops.
// Assumes both durations are at least one cycle. A start while it is
// running is filtered by the caller.
module poll_op_timer #(
    parameter int CHIP_CYCLES   = 5000,
    parameter int SECTOR_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_chip,
    input  logic load_sector,
    output logic running,
    output logic expire
);
    localparam int MAX_CYC = (CHIP_CYCLES > SECTOR_CYCLES) ? CHIP_CYCLES : SECTOR_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] CHIP_LOAD   = CNT_W'(CHIP_CYCLES - 1);
    localparam logic [CNT_W-1:0] SECTOR_LOAD = CNT_W'(SECTOR_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             run_q;

    // Load on start, count down while running, stop after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            run_q <= 1'b0;
        end else if (load_chip) begin
            cnt   <= CHIP_LOAD;
            run_q <= 1'b1;
        end else if (load_sector) begin
            cnt   <= SECTOR_LOAD;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Expiry is the last running cycle.
    always_comb begin
        running = run_q;
        expire  = run_q && (cnt == '0);
    end

    // R6
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (int'(cnt) < MAX_CYC));

    // R7
    timer_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load_chip && !load_sector) |=> !run_q);
endmodule

// File: rtl/poll_status_reg.sv
// Status byte register.
// Clears on an erase start, loads the polling bit from program data,
// inverts the polling bit on erase expiry and flips the toggle bit on
// every host read.
// Assumes the caller never asserts prog_wr and flip_poll together.
module poll_status_reg
    import flash_poll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              prog_wr,
    input  logic              prog_msb,
    input  logic              flip_poll,
    input  logic              rd,
    output logic [STAT_W-1:0] stat
);
    logic [STAT_W-1:0] stat_nx;

    // Next value: the clear wins; otherwise each bit merges its own events.
    always_comb begin
        stat_nx = stat;
        if (clr) begin
            stat_nx = '0;
        end else begin
            if (prog_wr) begin
                stat_nx[POLL_BIT] = ~prog_msb;
            end else if (flip_poll) begin
                stat_nx[POLL_BIT] = ~stat[POLL_BIT];
            end
            if (rd) begin
                stat_nx[TGL_BIT] = ~stat[TGL_BIT];
            end
        end
    end

    // Register the status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            stat <= stat_nx;
        end
    end

    // R2
    toggle_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !clr) |=> (stat[TGL_BIT] != $past(stat[TGL_BIT])));

    // R5
    clear_on_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (stat == '0));

    // R3
    low_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (stat[TGL_BIT-1:0] == $past(stat[TGL_BIT-1:0])));
endmodule

// File: rtl/flash_poll_status.sv
// Flash program/erase status poller, top level.
// Accepts program and erase starts when idle, tracks the current
// command, drives the erase timer and status byte, and issues the
// completion pulse.
// Assumes start pulses are one cycle wide. A program completes at the
// edge after it is accepted.
module flash_poll_status
    import flash_poll_pkg::*;
#(
    parameter int CHIP_CYCLES   = 5000,
    parameter int SECTOR_CYCLES = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_start,
    input  logic [7:0] prog_data,
    input  logic       chip_erase_start,
    input  logic       sector_erase_start,
    input  logic       status_rd,
    output logic [7:0] status_q,
    output logic       busy,
    output logic       op_done,
    output logic       cmd_active
);
    op_kind_e cmd_q;
    logic     idle;
    logic     chip_acc;
    logic     sect_acc;
    logic     prog_acc;
    logic     expire;
    logic     running;

    // Accept a start only when no command is current, chip first.
    always_comb begin
        idle     = (cmd_q == OP_IDLE);
        chip_acc = idle && chip_erase_start;
        sect_acc = idle && sector_erase_start && !chip_erase_start;
        prog_acc = idle && prog_start && !chip_erase_start && !sector_erase_start;
    end

    // Track the current command until it completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= OP_IDLE;
        end else if (chip_acc) begin
            cmd_q <= OP_CHIP;
        end else if (sect_acc) begin
            cmd_q <= OP_SECTOR;
        end else if (prog_acc) begin
            cmd_q <= OP_PROG;
        end else if (cmd_q == OP_PROG || expire) begin
            cmd_q <= OP_IDLE;
        end
    end

    // Completion pulse when a program retires or an erase expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_done <= 1'b0;
        end else begin
            op_done <= (cmd_q == OP_PROG) || expire;
        end
    end

    poll_op_timer #(
        .CHIP_CYCLES  (CHIP_CYCLES),
        .SECTOR_CYCLES(SECTOR_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_chip  (chip_acc),
        .load_sector(sect_acc),
        .running    (running),
        .expire     (expire)
    );

    poll_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (chip_acc || sect_acc),
        .prog_wr  (prog_acc),
        .prog_msb (prog_data[7]),
        .flip_poll(expire),
        .rd       (status_rd),
        .stat     (status_q)
    );

    // Drive the level outputs from the timer and command state.
    always_comb begin
        busy       = running;
        cmd_active = (cmd_q != OP_IDLE);
    end

    // R7
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> op_done);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    // R8
    busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(chip_erase_start || sector_erase_start));

    // R11
    active_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cmd_active);

    // R4
    prog_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == OP_PROG) |-> !busy);
endmodule

// File: tb/flash_poll_status_tb.sv
module flash_poll_status_tb;
    localparam int CHIP_N = 40;
    localparam int SECT_N = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_start = 1'b0;
    logic [7:0] prog_data = 8'h00;
    logic       chip_erase_start = 1'b0;
    logic       sector_erase_start = 1'b0;
    logic       status_rd = 1'b0;
    logic [7:0] status_q;
    logic       busy;
    logic       op_done;
    logic       cmd_active;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [7:0] stat;
        logic       bsy;
        logic       done;
        logic       act;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    // model state
    logic [7:0] m_stat = 8'h00;
    int         m_rem = 0;
    logic       m_ppend = 1'b0;
    logic       m_done = 1'b0;

    always #2 clk = ~clk;

    flash_poll_status #(
        .CHIP_CYCLES  (CHIP_N),
        .SECTOR_CYCLES(SECT_N)
    ) u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .prog_start        (prog_start),
        .prog_data         (prog_data),
        .chip_erase_start  (chip_erase_start),
        .sector_erase_start(sector_erase_start),
        .status_rd         (status_rd),
        .status_q          (status_q),
        .busy              (busy),
        .op_done           (op_done),
        .cmd_active        (cmd_active)
    );

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare outputs against the scoreboard in mid-cycle.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "status_q", status_q, e.stat);
            check(e.tag, "busy", {7'd0, busy}, {7'd0, e.bsy});
            check(e.tag, "op_done", {7'd0, op_done}, {7'd0, e.done});
            check(e.tag, "cmd_active", {7'd0, cmd_active}, {7'd0, e.act});
        end
    end

    // Driver: apply one cycle of stimulus, push expectations, advance the model.
    task automatic step(input string tag, input logic rd, input logic pg, input logic [7:0] pd,
                        input logic ch, input logic se);
        exp_t e;
        logic idle;
        @(posedge clk);
        #1;
        status_rd = rd; prog_start = pg; prog_data = pd;
        chip_erase_start = ch; sector_erase_start = se;
        e.stat = m_stat; e.bsy = (m_rem > 0); e.done = m_done;
        e.act = (m_rem > 0) || m_ppend; e.tag = tag;
        sb_q.push_back(e);
        idle = (m_rem == 0) && !m_ppend;
        m_done = m_ppend || (m_rem == 1);
        if (ch && idle) begin
            m_stat = 8'h00; m_rem = CHIP_N; m_ppend = 1'b0;
        end else if (se && idle) begin
            m_stat = 8'h00; m_rem = SECT_N; m_ppend = 1'b0;
        end else begin
            m_ppend = pg && idle;
            if (pg && idle) m_stat[7] = ~pd[7];
            if (m_rem == 1) m_stat[7] = ~m_stat[7];
            if (rd) m_stat[6] = ~m_stat[6];
            if (m_rem > 0) m_rem = m_rem - 1;
        end
    endtask

    task automatic idle_steps(input string tag, input int n, input logic rd);
        for (int i = 0; i < n; i++) step(tag, rd, 1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        status_rd = 0; prog_start = 0; chip_erase_start = 0; sector_erase_start = 0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_stat = 8'h00; m_rem = 0; m_ppend = 1'b0; m_done = 1'b0;
    endtask

    task automatic run_all();
        do_reset();
        // R1: reset state
        idle_steps("R1", 2, 1'b0);
        // R2: alternating polls
        idle_steps("R2", 5, 1'b1);
        idle_steps("R2", 1, 1'b0);
        // R3: program with data bit 7 set, then clear, with a read alongside
        step("R3", 1'b0, 1'b1, 8'h80, 1'b0, 1'b0);
        idle_steps("R4", 3, 1'b0);
        step("R3", 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0);
        idle_steps("R4", 3, 1'b1);
        // R8: program while a program completion is pending
        step("R8", 1'b0, 1'b1, 8'h80, 1'b0, 1'b0);
        step("R8", 1'b0, 1'b1, 8'h00, 1'b0, 1'b1);
        idle_steps("R8", 3, 1'b0);
        // R5/R6/R7: sector erase with polls every other cycle
        step("R5", 1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
        for (int i = 0; i < SECT_N + 3; i++) step("R6", (i % 2) == 1, 1'b0, 8'h00, 1'b0, 1'b0);
        // R6/R8: chip erase, pulses ignored while busy
        step("R6", 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        for (int i = 0; i < CHIP_N + 3; i++) begin
            if (i == 5) step("R8", 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
            else if (i == 10) step("R8", 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
            else if (i == 15) step("R8", 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
            else step("R7", (i % 3) == 0, 1'b0, 8'h00, 1'b0, 1'b0);
        end
        // R9: poll every cycle so one poll meets the expiry
        step("R9", 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        idle_steps("R9", SECT_N + 3, 1'b1);
        // R9: poll in the erase start cycle, toggle discarded
        step("R9", 1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
        idle_steps("R9", SECT_N + 2, 1'b0);
        // R10: chip and sector together, chip duration wins
        step("R10", 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        idle_steps("R10", CHIP_N + 2, 1'b0);
        // R10: sector and program together, sector wins
        step("R10", 1'b0, 1'b1, 8'h00, 1'b0, 1'b1);
        idle_steps("R11", SECT_N + 2, 1'b0);
        // R1: reset in the middle of a chip erase
        step("R1", 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        idle_steps("R1", 5, 1'b1);
        do_reset();
        idle_steps("R1", CHIP_N + 2, 1'b0);
        @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule